// File: doc/BRIEF.md
# CAN Operating-Mode Register and Sleep Controller

This block holds the 8-bit mode register of a CAN protocol controller and the small state machine that decides which operating mode the controller is in. A CPU writes and reads the register through a single-address port. The block turns the register contents into control signals for the rest of the controller. These signals hold the protocol engine in reset, block transmission in listen-only mode, relax the acknowledge rule in self-test mode, and hold the receiver off while the node sleeps or has not yet seen an idle bus. Bit timing, framing, CRC, arbitration and the error counters live elsewhere. They only consume these signals.

The mode state machine has four states. MS_RESET is configuration mode, and it is entered at hardware reset and whenever the reset bit is written to 1. MS_SYNC is operating mode before an idle bus has been seen, and the receiver is blocked there. MS_RUN is normal operation. MS_SLEEP is the low-power mode. The transitions are as follows. Reset-entry goes from any state to MS_RESET on a write with bit 0 set. Reset-exit goes from MS_RESET to MS_SYNC on a write with bit 0 clear. Sync-done goes from MS_SYNC to MS_RUN once the bus-free flag is high. Sleep-grant goes from MS_RUN to MS_SLEEP on an accepted sleep request. Sleep-reject keeps MS_RUN and raises a wake pulse. Software-wake goes from MS_SLEEP to MS_RUN when bit 4 is written to 0. Bus-wake goes from MS_SLEEP to MS_SYNC on a dominant bit sample.

A bus-free detector counts recessive samples taken on the bit strobe. It restarts on any dominant sample and saturates at 11. The receive input is polarity-corrected. In test mode the transmit pin loops the raw receive input back, one clock later.

Top module: `can_mode_ctrl`

## Requirements
- R1: After hardware reset the register reads 0x01 (reset bit set, all other bits 0), `core_reset` is 1, `tx_pin` is 1 (recessive) and `wake_irq` is 0.
- R2: Read data is only valid while `reg_sel` is 1, and it reads 0 otherwise. The read value places reset mode at bit 0, listen-only at bit 1, self-test at bit 2, sleep at bit 4, receive polarity at bit 5 and test mode at bit 7. Bits 3 and 6 always read 0, so writing 0xFF in reset mode reads back 0xA7.
- R3: A write changes bits 1, 2, 5 and 7 only if the block was already in MS_RESET before that write. Outside that state, those bits keep their value.
- R4: A write with bit 0 = 1 enters MS_RESET from any state on the next clock, clears the sleep state and raises `core_reset`. A write with bit 0 = 0 while in MS_RESET moves to MS_SYNC.
- R5: `bus_free` is 1 once 11 consecutive recessive samples have been taken on `bit_stb`. Any dominant sample clears the count, and the count is held at 0 while in MS_RESET.
- R6: In MS_SYNC, `rx_enable` is 0 and sleep requests are ignored without any wake pulse. The block moves to MS_RUN on the clock after `bus_free` is seen high, and `rx_enable` then becomes 1.
- R7: In MS_RUN, a write with bit 4 = 1 (and bit 0 = 0) moves to MS_SLEEP if `bus_free` = 1 and `irq_pending` = 0. After that, `sleeping` is 1 and bit 4 reads 1.
- R8: In MS_RUN, a sleep request made while `bus_free` = 0 or `irq_pending` = 1 leaves the block in MS_RUN with bit 4 reading 0, and it pulses `wake_irq` for one cycle.
- R9: In MS_SLEEP, a write with bit 4 = 0 (and bit 0 = 0) moves to MS_RUN and pulses `wake_irq`.
- R10: In MS_SLEEP, a dominant sample on `bit_stb` moves to MS_SYNC, clears bit 4 and pulses `wake_irq`. This takes priority over a write in the same cycle that does not set bit 0.
- R11: `rx_dom` equals `rx_raw` when the polarity bit is 1, and it equals the inverse of `rx_raw` when the polarity bit is 0.
- R12: With the test bit set, `tx_pin` takes the value of `rx_raw` on the next rising clock edge, whatever the polarity bit is.
- R13: `listen_only` and `self_test` follow bits 1 and 2. `tx_enable` is 1 only in MS_RUN with listen-only clear.
- R14: Outside test mode, `tx_pin` is registered. It takes the inverse of `tx_dom_req` when `tx_enable` is 1, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| reg_sel | input | 1 | Selects the mode register (address 0) |
| reg_wr | input | 1 | Write strobe, qualified by `reg_sel` |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, 0 when not selected |
| rx_raw | input | 1 | Raw receive pin level |
| bit_stb | input | 1 | One-cycle strobe at each bit sample point |
| irq_pending | input | 1 | Some controller interrupt is pending |
| tx_dom_req | input | 1 | Protocol engine wants a dominant bit |
| tx_pin | output | 1 | Transmit pin, 1 = recessive |
| rx_dom | output | 1 | Polarity-corrected receive level, 1 = dominant |
| rx_enable | output | 1 | Receiver allowed to accept frames |
| tx_enable | output | 1 | Transmitter allowed to drive the bus |
| core_reset | output | 1 | Holds the protocol engine in reset and aborts any frame |
| listen_only | output | 1 | Error-passive, no acknowledge, no error flags, counters frozen |
| self_test | output | 1 | Transmission succeeds without acknowledge |
| sleeping | output | 1 | Block is in MS_SLEEP |
| bus_free | output | 1 | 11 consecutive recessive samples seen |
| wake_irq | output | 1 | One-cycle wake-up interrupt pulse |

## Verification
The bench targets several corner cases. The first is a write to the locked bits outside configuration mode, which a design with a missing lock would let through. Another is the tenth versus eleventh recessive sample, where an off-by-one counter would declare the bus free too early or too late. It also covers sleep requests made while an interrupt is pending or the bus is busy, which a wrong design would accept silently instead of pulsing the wake interrupt. Finally, it checks that a bus wake lands in the synchronising state rather than in normal running, which would let the receiver accept a frame in mid-flight. Polarity inversion and the one-cycle loopback delay in test mode are driven with both polarity settings, and a reference model checks every output on every cycle of a long seeded random run.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    typedef enum logic [1:0] {
        MS_RESET = 2'd0,
        MS_SYNC  = 2'd1,
        MS_RUN   = 2'd2,
        MS_SLEEP = 2'd3
    } mode_state_t;

    localparam int unsigned REG_W       = 8;
    localparam int unsigned MB_RESET    = 0;
    localparam int unsigned MB_LISTEN   = 1;
    localparam int unsigned MB_SELFTEST = 2;
    localparam int unsigned MB_RSVD_A   = 3;
    localparam int unsigned MB_SLEEP    = 4;
    localparam int unsigned MB_POLARITY = 5;
    localparam int unsigned MB_RSVD_B   = 6;
    localparam int unsigned MB_TEST     = 7;
    localparam int unsigned BUS_IDLE_BITS = 11;

endpackage

// File: rtl/can_mode_bits.sv
module can_mode_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic in_reset,
    input  logic wd_listen,
    input  logic wd_selftest,
    input  logic wd_polarity,
    input  logic wd_test,
    output logic listen_only,
    output logic self_test,
    output logic rx_polarity,
    output logic test_loop
);

    // Locked configuration bits: only take a write when configuration
    // mode was already active before the write arrived.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            listen_only <= 1'b0;
            self_test   <= 1'b0;
            rx_polarity <= 1'b0;
            test_loop   <= 1'b0;
        end else if (wr_en && in_reset) begin
            listen_only <= wd_listen;
            self_test   <= wd_selftest;
            rx_polarity <= wd_polarity;
            test_loop   <= wd_test;
        end
    end

    // R3: locked bits hold their value for writes outside configuration mode
    p_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_reset) |=> $stable({listen_only, self_test, rx_polarity, test_loop}))
        else $error("p_locked_r3");

    // R3: a write inside configuration mode lands
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_reset) |=> (listen_only == $past(wd_listen)) && (test_loop == $past(wd_test)))
        else $error("p_write_lands_r3");

endmodule

// File: rtl/can_busfree_det.sv
module can_busfree_det #(
    parameter int unsigned BF_LEN = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bit_stb,
    input  logic rx_dom,
    output logic bus_free
);

    localparam int unsigned CW = $clog2(BF_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(BF_LEN);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (clr) begin
            run_cnt <= '0;
        end else if (bit_stb) begin
            if (rx_dom) begin
                run_cnt <= '0;
            end else if (run_cnt != FULL) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign bus_free = (run_cnt == FULL);

    // R5: the count never passes the saturation value
    p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= FULL)
        else $error("p_bound_r5");

    // R5: a dominant sample drops the bus-free flag
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && rx_dom) |=> !bus_free)
        else $error("p_restart_r5");

    // R5: without a strobe or clear the count holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_stb && !clr) |=> $stable(run_cnt))
        else $error("p_hold_r5");

    // R5: configuration mode holds the count at zero
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (run_cnt == '0))
        else $error("p_clear_r5");

endmodule

// File: rtl/can_sleep_fsm.sv
module can_sleep_fsm
    import can_mode_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wd_reset,
    input  logic        wd_sleep,
    input  logic        bus_free,
    input  logic        stb_dom,
    input  logic        irq_pending,
    output mode_state_t state,
    output logic        wake_irq,
    output logic        core_reset,
    output logic        rx_enable,
    output logic        sleeping,
    output logic        run_state
);

    mode_state_t nxt;
    logic        wake_evt;

    // State register and registered wake pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= MS_RESET;
            wake_irq <= 1'b0;
        end else begin
            state    <= nxt;
            wake_irq <= wake_evt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt      = state;
        wake_evt = 1'b0;
        if (wr_en && wd_reset) begin
            nxt = MS_RESET;                       // reset-entry
        end else begin
            unique case (state)
                MS_RESET: begin
                    if (wr_en) nxt = MS_SYNC;     // reset-exit
                end
                MS_SYNC: begin
                    if (bus_free) nxt = MS_RUN;   // sync-done
                end
                MS_RUN: begin
                    if (wr_en && wd_sleep) begin
                        if (bus_free && !irq_pending) begin
                            nxt = MS_SLEEP;       // sleep-grant
                        end else begin
                            wake_evt = 1'b1;      // sleep-reject
                        end
                    end
                end
                MS_SLEEP: begin
                    if (stb_dom) begin
                        nxt      = MS_SYNC;       // bus-wake
                        wake_evt = 1'b1;
                    end else if (wr_en && !wd_sleep) begin
                        nxt      = MS_RUN;        // software-wake
                        wake_evt = 1'b1;
                    end
                end
            endcase
        end
    end

    // Output decode
    always_comb begin
        core_reset = 1'b0;
        rx_enable  = 1'b0;
        sleeping   = 1'b0;
        run_state  = 1'b0;
        unique case (state)
            MS_RESET: core_reset = 1'b1;
            MS_SYNC:  ;
            MS_RUN: begin
                rx_enable = 1'b1;
                run_state = 1'b1;
            end
            MS_SLEEP: sleeping = 1'b1;
        endcase
    end

    // R4: a reset write wins from every state
    p_reset_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wd_reset) |=> (state == MS_RESET))
        else $error("p_reset_wins_r4");

    // R6: sync state only advances when the bus has been seen free
    p_sync_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MS_SYNC && !bus_free && !(wr_en && wd_reset)) |=> (state == MS_SYNC && !wake_irq))
        else $error("p_sync_gate_r6");

    // R7: an idle bus with no pending interrupt grants sleep
    p_sleep_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MS_RUN && wr_en && !wd_reset && wd_sleep && bus_free && !irq_pending)
        |=> (state == MS_SLEEP))
        else $error("p_sleep_grant_r7");

    // R8: a refused sleep request stays running and pulses wake
    p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MS_RUN && wr_en && !wd_reset && wd_sleep && !(bus_free && !irq_pending))
        |=> (state == MS_RUN && wake_irq))
        else $error("p_reject_r8");

    // R9: software wake
    p_sw_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MS_SLEEP && wr_en && !wd_reset && !wd_sleep && !stb_dom)
        |=> (state == MS_RUN && wake_irq))
        else $error("p_sw_wake_r9");

    // R10: bus activity wakes into the synchronising state
    p_bus_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MS_SLEEP && stb_dom && !(wr_en && wd_reset))
        |=> (state == MS_SYNC && wake_irq))
        else $error("p_bus_wake_r10");

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
    import can_mode_pkg::*;
#(
    parameter int unsigned IDLE_BITS = BUS_IDLE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             rx_raw,
    input  logic             bit_stb,
    input  logic             irq_pending,
    input  logic             tx_dom_req,
    output logic             tx_pin,
    output logic             rx_dom,
    output logic             rx_enable,
    output logic             tx_enable,
    output logic             core_reset,
    output logic             listen_only,
    output logic             self_test,
    output logic             sleeping,
    output logic             bus_free,
    output logic             wake_irq
);

    logic        wr_en;
    logic        rx_polarity;
    logic        test_loop;
    logic        stb_dom;
    logic        run_state;
    mode_state_t state;

    assign wr_en = reg_sel && reg_wr;

    can_mode_bits u_bits (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .in_reset    (core_reset),
        .wd_listen   (reg_wdata[MB_LISTEN]),
        .wd_selftest (reg_wdata[MB_SELFTEST]),
        .wd_polarity (reg_wdata[MB_POLARITY]),
        .wd_test     (reg_wdata[MB_TEST]),
        .listen_only (listen_only),
        .self_test   (self_test),
        .rx_polarity (rx_polarity),
        .test_loop   (test_loop)
    );

    // Polarity correction: 1 means dominant on the output
    assign rx_dom  = rx_polarity ? rx_raw : ~rx_raw;
    assign stb_dom = bit_stb && rx_dom;

    can_busfree_det #(
        .BF_LEN (IDLE_BITS)
    ) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (core_reset),
        .bit_stb  (bit_stb),
        .rx_dom   (rx_dom),
        .bus_free (bus_free)
    );

    can_sleep_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wd_reset    (reg_wdata[MB_RESET]),
        .wd_sleep    (reg_wdata[MB_SLEEP]),
        .bus_free    (bus_free),
        .stb_dom     (stb_dom),
        .irq_pending (irq_pending),
        .state       (state),
        .wake_irq    (wake_irq),
        .core_reset  (core_reset),
        .rx_enable   (rx_enable),
        .sleeping    (sleeping),
        .run_state   (run_state)
    );

    assign tx_enable = run_state && !listen_only;

    // Transmit pin register: loopback in test mode, else gated request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_pin <= 1'b1;
        end else if (test_loop) begin
            tx_pin <= rx_raw;
        end else begin
            tx_pin <= tx_enable ? ~tx_dom_req : 1'b1;
        end
    end

    // Read-back assembly; reserved positions are tied low
    always_comb begin
        reg_rdata = '0;
        if (reg_sel) begin
            reg_rdata[MB_RESET]    = core_reset;
            reg_rdata[MB_LISTEN]   = listen_only;
            reg_rdata[MB_SELFTEST] = self_test;
            reg_rdata[MB_SLEEP]    = sleeping;
            reg_rdata[MB_POLARITY] = rx_polarity;
            reg_rdata[MB_TEST]     = test_loop;
        end
    end

    // R2: writing the reserved positions never makes them read back
    p_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (reg_wdata[MB_RSVD_A] || reg_wdata[MB_RSVD_B]))
        |=> (reg_rdata[MB_RSVD_A] == 1'b0 && reg_rdata[MB_RSVD_B] == 1'b0))
        else $error("p_rsvd_r2");

    // R12: loopback follows the receive pin one clock later
    p_loop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        test_loop |=> (tx_pin == $past(rx_raw)))
        else $error("p_loop_r12");

    // R13: listen-only keeps the transmit pin recessive
    p_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (listen_only && !test_loop) |=> tx_pin)
        else $error("p_quiet_r13");

endmodule

// File: tb/test_can_mode_ctrl.sv
module test_can_mode_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_sel = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       rx_raw = 1'b1;
    logic       bit_stb = 1'b0;
    logic       irq_pending = 1'b0;
    logic       tx_dom_req = 1'b0;
    logic       tx_pin, rx_dom, rx_enable, tx_enable, core_reset;
    logic       listen_only, self_test, sleeping, bus_free, wake_irq;

    int checks = 0;
    int errors = 0;

    // reference model state: 0 reset, 1 sync, 2 run, 3 sleep
    int m_st = 0;
    bit m_lom = 0, m_stm = 0, m_rpm = 0, m_tm = 0;
    int m_cnt = 0;
    bit m_tx = 1, m_wake = 0;
    bit m_sel = 0;

    always #10 clk = ~clk;

    can_mode_ctrl i_can_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_raw(rx_raw),
        .bit_stb(bit_stb), .irq_pending(irq_pending), .tx_dom_req(tx_dom_req),
        .tx_pin(tx_pin), .rx_dom(rx_dom), .rx_enable(rx_enable),
        .tx_enable(tx_enable), .core_reset(core_reset),
        .listen_only(listen_only), .self_test(self_test),
        .sleeping(sleeping), .bus_free(bus_free), .wake_irq(wake_irq)
    );

    function automatic bit f_dom(bit rpm, bit rx);
        return rpm ? rx : !rx;
    endfunction

    function automatic logic [7:0] f_read(bit sel);
        if (!sel) return 8'h00;
        return {m_tm, 1'b0, m_rpm, (m_st == 3), 1'b0, m_stm, m_lom, (m_st == 0)};
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2 read data", reg_rdata, f_read(m_sel));
        chk("R8 wake_irq", {7'd0, wake_irq}, {7'd0, m_wake});
        chk("R6 rx_enable", {7'd0, rx_enable}, {7'd0, (m_st == 2)});
        chk("R14 tx_pin", {7'd0, tx_pin}, {7'd0, m_tx});
        chk("R5 bus_free", {7'd0, bus_free}, {7'd0, (m_cnt == 11)});
        chk("R4 core_reset", {7'd0, core_reset}, {7'd0, (m_st == 0)});
        chk("R7 sleeping", {7'd0, sleeping}, {7'd0, (m_st == 3)});
        chk("R13 listen_only", {7'd0, listen_only}, {7'd0, m_lom});
        chk("R13 self_test", {7'd0, self_test}, {7'd0, m_stm});
        chk("R13 tx_enable", {7'd0, tx_enable}, {7'd0, (m_st == 2 && !m_lom)});
    endtask

    // Called at a falling edge: drive, predict, clock, compare
    task automatic step(bit wr, logic [7:0] wd, bit rx, bit stb, bit irq, bit txq, bit sel);
        bit bf, sdom, wre;
        int n_st, n_cnt;
        bit n_wake, n_tx;
        reg_sel = sel; reg_wr = wr; reg_wdata = wd; rx_raw = rx;
        bit_stb = stb; irq_pending = irq; tx_dom_req = txq;
        #1;
        chk("R11 rx_dom", {7'd0, rx_dom}, {7'd0, f_dom(m_rpm, rx)});
        wre = wr && sel;
        bf = (m_cnt == 11);
        sdom = stb && f_dom(m_rpm, rx);
        n_st = m_st; n_wake = 0;
        if (wre && wd[0]) n_st = 0;
        else begin
            case (m_st)
                0: if (wre) n_st = 1;
                1: if (bf) n_st = 2;
                2: if (wre && wd[4]) begin
                       if (bf && !irq) n_st = 3; else n_wake = 1;
                   end
                default: begin
                    if (sdom) begin n_st = 1; n_wake = 1; end
                    else if (wre && !wd[4]) begin n_st = 2; n_wake = 1; end
                end
            endcase
        end
        if (m_st == 0) n_cnt = 0;
        else if (stb) n_cnt = sdom ? 0 : ((m_cnt < 11) ? m_cnt + 1 : m_cnt);
        else n_cnt = m_cnt;
        n_tx = m_tm ? rx : ((m_st == 2 && !m_lom) ? !txq : 1'b1);
        @(posedge clk);
        @(negedge clk);
        if (wre && m_st == 0) begin
            m_lom = wd[1]; m_stm = wd[2]; m_rpm = wd[5]; m_tm = wd[7];
        end
        m_st = n_st; m_cnt = n_cnt; m_wake = n_wake; m_tx = n_tx; m_sel = sel;
        compare_all();
    endtask

    task automatic idle(int n, bit stb);
        for (int i = 0; i < n; i++) step(0, 8'h00, !m_rpm, stb, 0, 0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reg_sel = 1'b1;
        #1;
        // R1: reset state
        chk("R1 reset read", reg_rdata, 8'h01);
        chk("R1 reset tx_pin", {7'd0, tx_pin}, 8'h01);
        chk("R1 reset core_reset", {7'd0, core_reset}, 8'h01);
        chk("R1 reset wake", {7'd0, wake_irq}, 8'h00);
        @(negedge clk);

        // R2: bit map and reserved bits
        step(1, 8'hFF, 1, 0, 0, 0, 1);
        chk("R2 all-ones readback", reg_rdata, 8'hA7);
        step(0, 8'h00, 1, 0, 0, 0, 0);
        chk("R2 deselected read", reg_rdata, 8'h00);
        step(1, 8'h01, 1, 0, 0, 0, 1);
        step(1, 8'h00, 1, 0, 0, 0, 1);
        chk("R4 leave reset", {7'd0, core_reset}, 8'h00);
        // R3: locked bits outside reset
        step(1, 8'hA6, 1, 0, 0, 0, 1);
        chk("R3 locked bits", reg_rdata, 8'h00);
        // R6: sleep request in sync ignored
        step(1, 8'h10, 1, 0, 0, 0, 1);
        chk("R6 sync sleep ignored", {6'd0, sleeping, wake_irq}, 8'h00);
        // R5: ten recessive samples do not suffice, eleven do
        idle(10, 1);
        chk("R5 ten samples", {7'd0, bus_free}, 8'h00);
        idle(1, 1);
        chk("R5 eleven samples", {7'd0, bus_free}, 8'h01);
        chk("R6 still blocked", {7'd0, rx_enable}, 8'h00);
        idle(1, 0);
        chk("R6 receiver enabled", {7'd0, rx_enable}, 8'h01);
        // R8: refused sleep with interrupt pending
        step(1, 8'h10, 1, 0, 1, 0, 1);
        chk("R8 refused sleep wake", {7'd0, wake_irq}, 8'h01);
        chk("R8 refused sleep bit", reg_rdata, 8'h00);
        // R7: granted sleep
        step(1, 8'h10, 1, 0, 0, 0, 1);
        chk("R7 sleep granted", reg_rdata, 8'h10);
        // R9: software wake
        step(1, 8'h00, 1, 0, 0, 0, 1);
        chk("R9 software wake", {6'd0, rx_enable, wake_irq}, 8'h03);
        // R10: bus wake with a competing write
        step(1, 8'h10, 1, 0, 0, 0, 1);
        step(1, 8'h10, 0, 1, 0, 0, 1);
        chk("R10 bus wake", {5'd0, sleeping, rx_enable, wake_irq}, 8'h01);
        // R14: transmission in run
        idle(12, 1);
        step(0, 8'h00, 1, 0, 0, 1, 1);
        chk("R14 dominant out", {7'd0, tx_pin}, 8'h00);
        // R4 and R12: loopback with both polarities
        step(1, 8'h01, 1, 0, 0, 0, 1);
        chk("R4 reset entry", {7'd0, core_reset}, 8'h01);
        step(1, 8'h81, 1, 0, 0, 0, 1);
        step(0, 8'h00, 0, 0, 0, 0, 1);
        chk("R12 loopback low", {7'd0, tx_pin}, 8'h00);
        step(1, 8'hA1, 1, 0, 0, 0, 1);
        chk("R12 loopback high", {7'd0, tx_pin}, 8'h01);
        step(0, 8'h00, 0, 0, 0, 0, 1);
        chk("R12 loopback ignores polarity", {7'd0, tx_pin}, 8'h00);
        chk("R11 polarity high", {7'd0, rx_dom}, 8'h00);
        // R13: listen-only keeps quiet
        step(1, 8'h07, 1, 0, 0, 0, 1);
        step(1, 8'h06, 1, 0, 0, 0, 1);
        idle(12, 1);
        step(0, 8'h00, 1, 0, 0, 1, 1);
        chk("R13 listen-only quiet", {6'd0, tx_enable, tx_pin}, 8'h01);
        chk("R13 self-test flag", {7'd0, self_test}, 8'h01);

        // Seeded random run against the model
        for (int n = 0; n < 6000; n++) begin
            bit wr, stb, irq, txq, sel, dom;
            logic [7:0] wd;
            wr  = ($urandom_range(0, 99) < 14);
            wd  = 8'($urandom);
            if (wd[0] && $urandom_range(0, 3) != 0) wd[0] = 1'b0;
            stb = ($urandom_range(0, 2) == 0);
            dom = ($urandom_range(0, 7) == 0);
            irq = ($urandom_range(0, 4) == 0);
            txq = 1'($urandom);
            sel = ($urandom_range(0, 3) != 0);
            step(wr, wd, m_rpm ? dom : !dom, stb, irq, txq, sel);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule